// File: doc/BRIEF.md
# MAC Array Self-Test Engine

This block qualifies a clock rate for an array of parallel multiply-accumulate lanes. On a start request it drives every lane at once from its own pseudo-random operand source. Each lane sums a fixed number of signed 16 x 16 products into a wide accumulator. At the end of each run the engine compares every lane's sum with a golden value supplied on an input bus. It repeats the run a fixed number of times.

Every run restarts the operand sources from their seeds, so the correct sum is the same on every repeat. A lane that ever disagrees is flagged, and its saturating error counter shows how many runs went wrong. When the last repeat has been compared, the engine raises a one-cycle done pulse. It also drives a pass level that is high only if no lane has a single mismatch across the whole test. A host sweeps the clock, starts the engine, and reads pass and the per-lane counts.

Top module: `mac_bist`

## Requirements
- R1: Each lane multiplies two signed two's complement 16-bit operands, sign-extends the 32-bit product to ACC_W (48) bits and adds it to its accumulator modulo 2^ACC_W.
- R2: Lane i draws operands from a 32-bit register seeded with (0x1D872B41 ^ (i * 0x9E3779B9 mod 2^32)) | 1. The first operand is bits [31:16] and the second is bits [15:0]. After each product the register advances to (s >> 1) ^ (s[0] ? 0x80200003 : 0). The register and the accumulator return to their seed and zero at the start of every run.
- R3: One run accumulates exactly RUN_LEN (1000) products. Lane i's sum is then compared with golden bits [ACC_W*i + ACC_W-1 : ACC_W*i].
- R4: Each mismatching compare adds one to that lane's error count, which is at bits [CNT_W*i + CNT_W-1 : CNT_W*i] of err_cnt. The count stops at 2^CNT_W-1 (15) and never decreases except on start.
- R5: A lane's fail_lane bit is set by its first mismatch and stays set until the next start.
- R6: One test is REPEATS (32) runs. busy is high from the cycle after start until done. done is a single-cycle pulse after the last compare, with busy low in that cycle.
- R7: When done pulses, pass is high exactly when no lane recorded any mismatch. pass then holds until the next start, and it is low whenever busy is high.
- R8: A start, even in the middle of a test, clears all counts, fail bits and pass, and begins a new test from the first run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock under qualification |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin (or restart) a test |
| golden | input | LANES*ACC_W | Expected final sum per lane, lane 0 in the low bits |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle pulse at test end |
| pass | output | 1 | Last finished test had zero mismatches |
| fail_lane | output | LANES | Sticky per-lane mismatch flags |
| err_cnt | output | LANES*CNT_W | Saturating per-lane mismatch counts |

## Verification
A wrong operand sequence, a wrong sign extension or an accumulator that carries over from the last run shows up as non-zero error counts and fail bits. These appear at the end of the first run, about RUN_LEN+2 cycles after start, and they hold through done. A stuck or miscounting error counter shows as a count that differs from the number of bad runs, or that wraps past 15 over 32 runs. A sequencer that miscounts repeats shifts done away from its expected cycle or pulses it for more than one cycle. A restart that fails to clear its state leaves stale counts visible at the next done.

// File: rtl/mac_bist_pkg.sv
package mac_bist_pkg;

  localparam int OP_W   = 16;
  localparam int PROD_W = 2 * OP_W;
  localparam int SRC_W  = 32;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_RUN,
    S_CHECK,
    S_FINISH
  } seq_state_t;

  // Operand source advance: right shift with feedback mask.
  function automatic logic [SRC_W-1:0] src_next(input logic [SRC_W-1:0] s);
    return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0000_0000);
  endfunction

  // Per-lane nonzero start value.
  function automatic logic [SRC_W-1:0] src_seed(input int unsigned idx);
    logic [SRC_W-1:0] mix;
    mix = 32'(idx) * 32'h9E37_79B9;
    return (32'h1D87_2B41 ^ mix) | 32'h0000_0001;
  endfunction

  // Signed product of the two operand halves.
  function automatic logic signed [PROD_W-1:0] src_product(input logic [SRC_W-1:0] s);
    logic signed [OP_W-1:0] a;
    logic signed [OP_W-1:0] b;
    a = s[SRC_W-1:OP_W];
    b = s[OP_W-1:0];
    return a * b;
  endfunction

endpackage

// File: rtl/mac_bist_seq.sv
module mac_bist_seq
  import mac_bist_pkg::*;
#(
  parameter int RUN_LEN = 1000,
  parameter int REPEATS = 32,
  localparam int STEP_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1,
  localparam int REP_W  = (REPEATS > 1) ? $clog2(REPEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              load,
  output logic              run,
  output logic              check,
  output logic              finish,
  output logic              busy,
  output logic              done,
  output logic [STEP_W-1:0] step_cnt
);

  seq_state_t       state;
  logic [REP_W-1:0] rep_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      step_cnt <= '0;
      rep_cnt  <= '0;
      done     <= 1'b0;
    end else begin
      done <= (state == S_FINISH) && !start;
      if (start) begin
        state    <= S_LOAD;
        step_cnt <= '0;
        rep_cnt  <= '0;
      end else begin
        case (state)
          S_LOAD: begin
            step_cnt <= '0;
            state    <= S_RUN;
          end
          S_RUN: begin
            if (step_cnt == STEP_W'(RUN_LEN - 1)) state <= S_CHECK;
            else step_cnt <= step_cnt + 1'b1;
          end
          S_CHECK: begin
            if (rep_cnt == REP_W'(REPEATS - 1)) begin
              state <= S_FINISH;
            end else begin
              rep_cnt <= rep_cnt + 1'b1;
              state   <= S_LOAD;
            end
          end
          S_FINISH: state <= S_IDLE;
          default:  state <= S_IDLE;
        endcase
      end
    end
  end

  assign load   = (state == S_LOAD);
  assign run    = (state == S_RUN);
  assign check  = (state == S_CHECK);
  assign finish = (state == S_FINISH);
  assign busy   = (state != S_IDLE);

endmodule

// File: rtl/mac_bist_lane.sv
module mac_bist_lane
  import mac_bist_pkg::*;
#(
  parameter int LANE_IDX = 0,
  parameter int ACC_W    = 48,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic             run,
  input  logic             check,
  input  logic [ACC_W-1:0] golden,
  output logic             mismatch,
  output logic [CNT_W-1:0] err_cnt,
  output logic             fail
);

  localparam logic [SRC_W-1:0] SEED    = src_seed(LANE_IDX);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SRC_W-1:0]        src;
  logic [ACC_W-1:0]        acc;
  logic signed [PROD_W-1:0] prod;
  logic [ACC_W-1:0]        prod_ext;

  assign prod     = src_product(src);
  assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  assign mismatch = check && (acc != golden);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src <= SEED;
      acc <= '0;
    end else if (clear || load) begin
      src <= SEED;
      acc <= '0;
    end else if (run) begin
      src <= src_next(src);
      acc <= acc + prod_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cnt <= '0;
      fail    <= 1'b0;
    end else if (clear) begin
      err_cnt <= '0;
      fail    <= 1'b0;
    end else if (mismatch) begin
      fail <= 1'b1;
      if (err_cnt != CNT_MAX) err_cnt <= err_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/mac_bist.sv
module mac_bist
  import mac_bist_pkg::*;
#(
  parameter int LANES   = 30,
  parameter int ACC_W   = 48,
  parameter int CNT_W   = 4,
  parameter int RUN_LEN = 1000,
  parameter int REPEATS = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [LANES*ACC_W-1:0] golden,
  output logic                   busy,
  output logic                   done,
  output logic                   pass,
  output logic [LANES-1:0]       fail_lane,
  output logic [LANES*CNT_W-1:0] err_cnt
);

  localparam int STEP_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;

  logic              load, run, check, finish;
  logic [STEP_W-1:0] step_cnt;
  logic [LANES-1:0]  mismatch;

  mac_bist_seq #(
    .RUN_LEN(RUN_LEN),
    .REPEATS(REPEATS)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .load    (load),
    .run     (run),
    .check   (check),
    .finish  (finish),
    .busy    (busy),
    .done    (done),
    .step_cnt(step_cnt)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    mac_bist_lane #(
      .LANE_IDX(i),
      .ACC_W   (ACC_W),
      .CNT_W   (CNT_W)
    ) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (start),
      .load    (load),
      .run     (run),
      .check   (check),
      .golden  (golden[i*ACC_W +: ACC_W]),
      .mismatch(mismatch[i]),
      .err_cnt (err_cnt[i*CNT_W +: CNT_W]),
      .fail    (fail_lane[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pass <= 1'b0;
    else if (start)  pass <= 1'b0;
    else if (finish) pass <= ~|fail_lane;
  end

endmodule

// File: rtl/mac_bist_chk.sv
module mac_bist_chk #(
  parameter int LANES   = 30,
  parameter int CNT_W   = 4,
  parameter int RUN_LEN = 1000,
  parameter int STEP_W  = 10
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   busy,
  input logic                   done,
  input logic                   pass,
  input logic [LANES-1:0]       fail_lane,
  input logic [LANES*CNT_W-1:0] err_cnt,
  input logic [STEP_W-1:0]      step_cnt
);

  assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_cnt < STEP_W'(RUN_LEN));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_pass_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> (fail_lane == '0));

  assert_pass_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pass);

  assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !pass && fail_lane == '0 && err_cnt == '0));

  for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
    logic [CNT_W-1:0] cnt;
    assign cnt = err_cnt[i*CNT_W +: CNT_W];

    assert_cnt_flag_agree_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) == fail_lane[i]);

    assert_cnt_monotone_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> cnt >= $past(cnt));

    assert_fail_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_lane[i] && !start) |=> fail_lane[i]);
  end

endmodule

bind mac_bist mac_bist_chk #(
  .LANES  (LANES),
  .CNT_W  (CNT_W),
  .RUN_LEN(RUN_LEN),
  .STEP_W (STEP_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .pass     (pass),
  .fail_lane(fail_lane),
  .err_cnt  (err_cnt),
  .step_cnt (step_cnt)
);

// File: tb/mac_bist_test.sv
module mac_bist_test;

  localparam int LANES   = 30;
  localparam int ACC_W   = 48;
  localparam int CNT_W   = 4;
  localparam int RUN_LEN = 1000;
  localparam int REPEATS = 32;
  localparam int CMAX    = (1 << CNT_W) - 1;
  localparam int SAT     = (REPEATS > CMAX) ? CMAX : REPEATS;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   start = 1'b0;
  logic [LANES*ACC_W-1:0] golden = '0;
  logic                   busy, done, pass;
  logic [LANES-1:0]       fail_lane;
  logic [LANES*CNT_W-1:0] err_cnt;

  int n_tests = 0;
  int n_fail  = 0;
  int seen    = 0;
  int want    = 0;

  typedef struct {
    int cnt[LANES];
    bit pass_exp;
  } exp_t;
  exp_t exp_q[$];

  logic [LANES*ACC_W-1:0] good_gold;

  always #5 clk = ~clk;

  mac_bist #(
    .LANES(LANES), .ACC_W(ACC_W), .CNT_W(CNT_W),
    .RUN_LEN(RUN_LEN), .REPEATS(REPEATS)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .golden(golden),
    .busy(busy), .done(done), .pass(pass),
    .fail_lane(fail_lane), .err_cnt(err_cnt)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // Reference sum restated from R1/R2/R3.
  function automatic logic [ACC_W-1:0] model_sum(input int lane);
    logic [31:0] r;
    longint total;
    r = (32'h1D87_2B41 ^ (32'(lane) * 32'h9E37_79B9)) | 32'd1;
    total = 0;
    for (int k = 0; k < RUN_LEN; k++) begin
      longint x, y;
      x = longint'($signed(r[31:16]));
      y = longint'($signed(r[15:0]));
      total = total + x * y;
      r = {1'b0, r[31:1]} ^ (r[0] ? 32'h8020_0003 : 32'h0);
    end
    return total[ACC_W-1:0];
  endfunction

  // Driver: push the expectation, then pulse start.
  task automatic launch(input logic [LANES*ACC_W-1:0] g, input exp_t e, input bit push);
    @(negedge clk);
    golden = g;
    start  = 1'b1;
    if (push) begin
      exp_q.push_back(e);
      want++;
    end
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R6", "busy after start", longint'(busy), 1);
    chk(pass == 1'b0 && fail_lane == '0 && err_cnt == '0, "R8", "cleared by start",
        longint'(fail_lane), 0);
  endtask

  // Monitor: compare each finished test with the queued expectation.
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          for (int i = 0; i < LANES; i++) begin
            int a;
            a = int'(err_cnt[i*CNT_W +: CNT_W]);
            chk(a == e.cnt[i], "R4", $sformatf("lane %0d error count", i), a, e.cnt[i]);
            chk(fail_lane[i] == (e.cnt[i] != 0), "R5", $sformatf("lane %0d fail flag", i),
                longint'(fail_lane[i]), longint'(e.cnt[i] != 0));
          end
          chk(pass == e.pass_exp, "R7", "pass at done", longint'(pass), longint'(e.pass_exp));
          chk(busy == 1'b0, "R6", "busy low with done", longint'(busy), 0);
        end
        @(negedge clk);
        chk(done == 1'b0, "R6", "done one cycle", longint'(done), 0);
        seen++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    exp_t e_ok, e_bad;
    logic [LANES*ACC_W-1:0] bad_gold;

    for (int i = 0; i < LANES; i++) good_gold[i*ACC_W +: ACC_W] = model_sum(i);
    bad_gold = good_gold;
    bad_gold[3*ACC_W +: ACC_W] = good_gold[3*ACC_W +: ACC_W] + 48'd1;
    bad_gold[7*ACC_W + ACC_W-1] = ~good_gold[7*ACC_W + ACC_W-1];

    for (int i = 0; i < LANES; i++) begin
      e_ok.cnt[i]  = 0;
      e_bad.cnt[i] = (i == 3 || i == 7) ? SAT : 0;
    end
    e_ok.pass_exp  = 1'b1;
    e_bad.pass_exp = 1'b0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && pass == 0, "R6", "reset outputs", longint'({busy, done, pass}), 0);
    chk(fail_lane == '0 && err_cnt == '0, "R5", "reset flags", longint'(fail_lane), 0);

    // R1 R2 R3: matching golden gives zero errors and pass.
    launch(good_gold, e_ok, 1'b1);
    wait (seen == want);
    repeat (20) @(negedge clk);
    chk(pass == 1'b1, "R7", "pass held in idle", longint'(pass), 1);

    // R4 saturation, R5 sticky flags: two lanes with wrong golden.
    launch(bad_gold, e_bad, 1'b1);
    wait (seen == want);

    // R8: restart mid-test after one bad run.
    launch(bad_gold, e_bad, 1'b0);
    repeat (RUN_LEN + 20) @(negedge clk);
    chk(int'(err_cnt[3*CNT_W +: CNT_W]) == 1, "R4", "one bad run counted once",
        longint'(err_cnt[3*CNT_W +: CNT_W]), 1);
    chk(fail_lane[7] == 1'b1 && busy == 1'b1, "R5", "flag set mid-test",
        longint'(fail_lane[7]), 1);
    launch(good_gold, e_ok, 1'b1);
    wait (seen == want);
    repeat (5) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule